// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block gives a processor sixteen prioritized, level-sensitive hardware interrupt lines. Two identical eight-input stages do the work. The secondary stage takes lines 8 to 15. The primary stage takes lines 0 to 7, except that its input 2 is not fed from outside. That input carries the secondary stage's interrupt output instead. Each stage has its own vector base, mask, request view and in-service register. The processor sees one interrupt output. It answers with an acknowledge pulse, and the block returns an eight-bit vector on the following cycle.

Software sets the masks and vector bases through a small register port. It writes a non-specific end-of-interrupt command to each stage on its own. After reset the two bases are 0x08 and 0x70, so primary vectors overlap the processor's exception range until software moves them, typically to 0x20 and 0x28. A line served through the secondary stage stays in service on both stages. It is released only after each stage has received its own end-of-interrupt.

Register map: address bit 2 selects the stage (0 primary, 1 secondary). Address bits 1:0 select the register: 0 is the mask (read/write), 1 is the vector base (read/write), 2 is the request view (read) or the end-of-interrupt command (write, data ignored), and 3 is the in-service register (read only).

Top module: `irq_cascade_top`

## Requirements
- R1: After reset both masks read 0xFF, the primary base reads 0x08, the secondary base reads 0x70, both in-service registers read 0x00, and cpu_int and vec_vld are low.
- R2: Input irq_lines[k] for k in 0..7 (except 2) is primary line k. irq_lines[8+k] is secondary line k. irq_lines[2] is ignored. The secondary interrupt output acts as primary line 2.
- R3: The returned vector is the winning stage's base plus the line index within that stage. When primary line 2 wins, the vector comes from the secondary stage. Mask and base read back as written. The request view shows the sampled request lines of the stage.
- R4: Mask bit k set to 1 stops stage line k from raising an interrupt. Writing a mask changes no in-service bit and no other line's behaviour.
- R5: Within a stage, a lower index has higher priority. cpu_int is high only when the best unmasked primary request is strictly higher in priority than every primary in-service bit. The secondary stage applies the same rule to drive its cascade output.
- R6: An acknowledge sets the winning bit in the primary in-service register. For a cascade win it also sets the winning secondary bit.
- R7: A non-specific end-of-interrupt clears only the highest-priority in-service bit of the addressed stage. A line from 8 to 15 needs one to each stage before primary line 2 can win again.
- R8: An acknowledge while cpu_int is low returns the primary base plus 7 and changes no in-service bit. This includes a request that was withdrawn before the acknowledge.
- R9: A change on irq_lines reaches cpu_int after one clock edge. vec_vld is high, with ack_vector valid, for exactly the cycle after each int_ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Level interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: bit 2 stage, bits 1:0 register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address, same layout |
| rd_data | output | 8 | Combinational read data |
| cpu_int | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge, one cycle per interrupt |
| vec_vld | output | 1 | Vector valid, cycle after acknowledge |
| ack_vector | output | 8 | Returned interrupt vector |

## Verification
A wrong in-service bit appears at the ports as an interrupt that is either lost or arrives at the wrong time. A stale bit holds cpu_int low for a higher line that should preempt, and the effect shows in the cycle after the request line rises. A missing bit lets a lower line through at the next acknowledge. A bad vector base or winner index appears directly in ack_vector one cycle after int_ack. The nesting sequence across the cascade exposes a missing or doubled end-of-interrupt within the next request cycle.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int STAGE_W = 8;
  localparam int IDX_W   = $clog2(STAGE_W);
  localparam int VEC_W   = 8;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_REQ  = 2'd2,
    REG_ISR  = 2'd3
  } reg_sel_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                               input logic [IDX_W-1:0] idx);
    return base + VEC_W'(idx);
  endfunction

  function automatic logic [STAGE_W-1:0] bit_at(input logic [IDX_W-1:0] idx);
    return STAGE_W'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_stage.sv
module irq_stage
  import irq_cascade_pkg::*;
#(
  parameter logic [STAGE_W-1:0] MASK_RST = '1,
  parameter logic [VEC_W-1:0]   BASE_RST = 8'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAGE_W-1:0] req_i,
  input  logic               mask_we,
  input  logic               base_we,
  input  logic [VEC_W-1:0]   wr_d,
  input  logic               eoi_i,
  input  logic               ack_i,
  output logic               int_o,
  output logic [IDX_W-1:0]   win_o,
  output logic [STAGE_W-1:0] pend_o,
  output logic [STAGE_W-1:0] mask_o,
  output logic [VEC_W-1:0]   base_o,
  output logic [STAGE_W-1:0] isr_o
);
  logic [STAGE_W-1:0] mask_q, isr_q, set_v, clr_v;
  logic [VEC_W-1:0]   base_q;
  logic               p_found, s_found;
  logic [IDX_W-1:0]   p_idx, s_idx;

  assign pend_o = req_i & ~mask_q;

  irq_prio_enc #(.W(STAGE_W)) u_pend_enc (.vec_i(pend_o), .found_o(p_found), .idx_o(p_idx));
  irq_prio_enc #(.W(STAGE_W)) u_isr_enc  (.vec_i(isr_q),  .found_o(s_found), .idx_o(s_idx));

  assign int_o = p_found && (!s_found || (p_idx < s_idx));
  assign win_o = p_idx;
  assign set_v = (ack_i && int_o) ? bit_at(p_idx) : '0;
  assign clr_v = (eoi_i && s_found) ? bit_at(s_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      base_q <= BASE_RST;
      isr_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wr_d;
      if (base_we) base_q <= wr_d;
      isr_q <= (isr_q & ~clr_v) | set_v;
    end
  end

  assign mask_o = mask_q;
  assign base_o = base_q;
  assign isr_o  = isr_q;
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter int               CASCADE_LINE = 2,
  parameter logic [VEC_W-1:0] PRI_BASE_RST = 8'h08,
  parameter logic [VEC_W-1:0] SEC_BASE_RST = 8'h70,
  localparam int              LINES        = 2 * STAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             cpu_int,
  input  logic             int_ack,
  output logic             vec_vld,
  output logic [7:0]       ack_vector
);
  localparam logic [IDX_W-1:0] CASC_IDX  = IDX_W'(CASCADE_LINE);
  localparam logic [IDX_W-1:0] SPUR_IDX  = IDX_W'(STAGE_W - 1);

  logic [LINES-1:0]   line_q;
  logic [STAGE_W-1:0] pri_req, sec_req;
  logic               pri_int, sec_int;
  logic [IDX_W-1:0]   pri_win, sec_win;
  logic [STAGE_W-1:0] pri_pend, sec_pend, pri_mask, sec_mask, pri_isr, sec_isr;
  logic [VEC_W-1:0]   pri_base, sec_base, vec_d;
  reg_sel_e           wsel, rsel;
  logic               pri_mask_we, sec_mask_we, pri_base_we, sec_base_we;
  logic               pri_eoi, sec_eoi, sec_ack, casc_win, mask_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= irq_lines;
  end

  // write decode
  assign wsel        = reg_sel_e'(wr_addr[1:0]);
  assign pri_mask_we = wr_en && !wr_addr[2] && (wsel == REG_MASK);
  assign sec_mask_we = wr_en &&  wr_addr[2] && (wsel == REG_MASK);
  assign pri_base_we = wr_en && !wr_addr[2] && (wsel == REG_BASE);
  assign sec_base_we = wr_en &&  wr_addr[2] && (wsel == REG_BASE);
  assign pri_eoi     = wr_en && !wr_addr[2] && (wsel == REG_REQ);
  assign sec_eoi     = wr_en &&  wr_addr[2] && (wsel == REG_REQ);
  assign mask_wr     = pri_mask_we || sec_mask_we;

  // request routing: the cascade input of the primary is the secondary output
  assign sec_req = line_q[LINES-1:STAGE_W];
  always_comb begin
    pri_req               = line_q[STAGE_W-1:0];
    pri_req[CASCADE_LINE] = sec_int;
  end

  assign casc_win = pri_int && (pri_win == CASC_IDX);
  assign sec_ack  = int_ack && casc_win;

  irq_stage #(.MASK_RST('1), .BASE_RST(SEC_BASE_RST)) u_sec (
    .clk, .rst_n, .req_i(sec_req), .mask_we(sec_mask_we), .base_we(sec_base_we),
    .wr_d(wr_data), .eoi_i(sec_eoi), .ack_i(sec_ack), .int_o(sec_int),
    .win_o(sec_win), .pend_o(sec_pend), .mask_o(sec_mask), .base_o(sec_base),
    .isr_o(sec_isr)
  );

  irq_stage #(.MASK_RST('1), .BASE_RST(PRI_BASE_RST)) u_pri (
    .clk, .rst_n, .req_i(pri_req), .mask_we(pri_mask_we), .base_we(pri_base_we),
    .wr_d(wr_data), .eoi_i(pri_eoi), .ack_i(int_ack), .int_o(pri_int),
    .win_o(pri_win), .pend_o(pri_pend), .mask_o(pri_mask), .base_o(pri_base),
    .isr_o(pri_isr)
  );

  assign cpu_int = pri_int;

  // vector selection
  always_comb begin
    if (!pri_int)      vec_d = vec_of(pri_base, SPUR_IDX);
    else if (casc_win) vec_d = vec_of(sec_base, sec_win);
    else               vec_d = vec_of(pri_base, pri_win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_vld    <= 1'b0;
      ack_vector <= '0;
    end else begin
      vec_vld <= int_ack;
      if (int_ack) ack_vector <= vec_d;
    end
  end

  // read mux
  assign rsel = reg_sel_e'(rd_addr[1:0]);
  always_comb begin
    unique case (rsel)
      REG_MASK: rd_data = rd_addr[2] ? sec_mask : pri_mask;
      REG_BASE: rd_data = rd_addr[2] ? sec_base : pri_base;
      REG_REQ:  rd_data = rd_addr[2] ? sec_req  : pri_req;
      default:  rd_data = rd_addr[2] ? sec_isr  : pri_isr;
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_int,
  input logic       int_ack,
  input logic       vec_vld,
  input logic [7:0] ack_vector,
  input logic [7:0] pri_isr,
  input logic [7:0] sec_isr,
  input logic [7:0] pri_pend,
  input logic [7:0] pri_base,
  input logic       pri_eoi,
  input logic       sec_eoi,
  input logic       mask_wr
);
  a_r5_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> (pri_pend != 8'h00));

  a_r6_ack_adds_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && cpu_int && !pri_eoi) |=> ($countones(pri_isr) == $countones($past(pri_isr)) + 1));

  a_r7_eoi_drops_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_eoi && !int_ack && (pri_isr != 8'h00)) |=> ($countones(pri_isr) == $countones($past(pri_isr)) - 1));

  a_r8_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cpu_int) |=> (vec_vld && (ack_vector == 8'($past(pri_base) + 8'd7))));

  a_r8_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cpu_int && !pri_eoi) |=> $stable(pri_isr));

  a_r4_mask_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !int_ack && !pri_eoi && !sec_eoi) |=> ($stable(pri_isr) && $stable(sec_isr)));

  a_r9_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> vec_vld);

  a_r9_no_vld_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> !vec_vld);
endmodule

bind irq_cascade_top irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_int(cpu_int), .int_ack(int_ack),
  .vec_vld(vec_vld), .ack_vector(ack_vector), .pri_isr(pri_isr),
  .sec_isr(sec_isr), .pri_pend(pri_pend), .pri_base(pri_base),
  .pri_eoi(pri_eoi), .sec_eoi(sec_eoi), .mask_wr(mask_wr)
);

// File: tb/irq_cascade_top_test.sv
`timescale 1ns/1ps
module irq_cascade_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        cpu_int, int_ack = 1'b0, vec_vld;
  logic [7:0]  ack_vector;
  int          n_chk = 0, n_fail = 0;

  localparam logic [2:0] P_MASK = 3'd0, P_BASE = 3'd1, P_REQ = 3'd2, P_ISR = 3'd3;
  localparam logic [2:0] S_MASK = 3'd4, S_BASE = 3'd5, S_REQ = 3'd6, S_ISR = 3'd7;

  always #2.5 clk = ~clk;

  irq_cascade_top uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_int(cpu_int),
    .int_ack(int_ack), .vec_vld(vec_vld), .ack_vector(ack_vector)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a; #0.2; v = rd_data;
  endtask

  task automatic ack(output logic [7:0] v);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    chk("R9 vec_vld after ack", 16'(vec_vld), 16'd1);
    v = ack_vector;
  endtask

  task automatic eoi_for(input int line);
    if (line >= 8) wr(S_REQ, 8'h00);
    wr(P_REQ, 8'h00);
  endtask

  // priority key: primary index major, secondary index minor
  function automatic int key_of(input int line);
    return (line < 8) ? line * 8 : 2 * 8 + (line - 8);
  endfunction

  function automatic logic [7:0] exp_vec(input int line, input int pb, input int sb);
    return 8'((line < 8) ? pb + line : sb + line - 8);
  endfunction

  task automatic sweep(input int pb, input int sb);
    logic [7:0] v;
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      irq = 16'(1) << l;
      #0.2;
      chk("R9 int not before edge", 16'(cpu_int), 16'd0);
      step();
      chk("R5 int for single line", 16'(cpu_int), 16'd1);
      ack(v);
      chk("R3 vector single line", 16'(v), 16'(exp_vec(l, pb, sb)));
      rd(P_ISR, v);
      chk("R6 primary isr", 16'(v), 16'((l < 8) ? (1 << l) : 4));
      rd(S_ISR, v);
      chk("R6 secondary isr", 16'(v), 16'((l >= 8) ? (1 << (l - 8)) : 0));
      irq = '0;
      eoi_for(l);
      rd(P_ISR, v);
      chk("R7 primary isr cleared", 16'(v), 16'd0);
      rd(S_ISR, v);
      chk("R7 secondary isr cleared", 16'(v), 16'd0);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(P_MASK, v); chk("R1 primary mask", 16'(v), 16'hFF);
    rd(S_MASK, v); chk("R1 secondary mask", 16'(v), 16'hFF);
    rd(P_BASE, v); chk("R1 primary base", 16'(v), 16'h08);
    rd(S_BASE, v); chk("R1 secondary base", 16'(v), 16'h70);
    rd(P_ISR, v);  chk("R1 primary isr", 16'(v), 16'h00);
    rd(S_ISR, v);  chk("R1 secondary isr", 16'(v), 16'h00);
    chk("R1 cpu_int", 16'(cpu_int), 16'd0);
    chk("R1 vec_vld", 16'(vec_vld), 16'd0);

    // R4 all masked, R2 line 2 ignored, R3 request view
    irq = 16'hFFFF;
    step(); step();
    chk("R4 full mask blocks", 16'(cpu_int), 16'd0);
    rd(P_REQ, v); chk("R2 primary request view", 16'(v), 16'hFB);
    rd(S_REQ, v); chk("R3 secondary request view", 16'(v), 16'hFF);
    irq = 16'h0004;
    wr(P_MASK, 8'h00);
    step();
    chk("R2 line 2 ignored", 16'(cpu_int), 16'd0);
    irq = '0;
    wr(S_MASK, 8'h00);
    rd(S_MASK, v); chk("R3 mask readback", 16'(v), 16'h00);

    // reset vectors collide with exception range (R1, R3)
    sweep(8'h08, 8'h70);
    wr(P_BASE, 8'h20);
    wr(S_BASE, 8'h28);
    rd(P_BASE, v); chk("R3 primary base readback", 16'(v), 16'h20);
    rd(S_BASE, v); chk("R3 secondary base readback", 16'(v), 16'h28);
    sweep(8'h20, 8'h28);

    // R5 pairwise priority sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a == 2 || b == 2) continue;
        begin
          int w;
          w = (key_of(a) < key_of(b)) ? a : b;
          irq = (16'(1) << a) | (16'(1) << b);
          step();
          ack(v);
          chk("R5 pair winner vector", 16'(v), 16'(exp_vec(w, 8'h20, 8'h28)));
          irq = '0;
          eoi_for(w);
        end
      end
    end

    // R4 single mask bit, mask write keeps in-service state
    irq = (16'(1) << 3) | (16'(1) << 6);
    wr(P_MASK, 8'h08);
    chk("R4 masked line skipped", 16'(cpu_int), 16'd1);
    ack(v);
    chk("R4 vector of unmasked line", 16'(v), 16'h26);
    wr(P_MASK, 8'h00);
    rd(P_ISR, v); chk("R4 isr unchanged by mask", 16'(v), 16'h40);
    chk("R5 unmasked higher line preempts", 16'(cpu_int), 16'd1);
    ack(v);
    chk("R5 preempting vector", 16'(v), 16'h23);
    irq = '0;
    wr(P_REQ, 8'h00);
    rd(P_ISR, v); chk("R7 highest isr bit cleared", 16'(v), 16'h40);
    wr(P_REQ, 8'h00);

    // nested preemption across the cascade
    irq = 16'(1) << 5; step(); ack(v);
    chk("R3 nest base line 5", 16'(v), 16'h25);
    irq = 16'(1) << 12; step();
    chk("R5 cascade preempts line 5", 16'(cpu_int), 16'd1);
    ack(v);
    chk("R3 cascade vector line 12", 16'(v), 16'h2C);
    irq = 16'(1) << 1; step();
    chk("R5 line 1 preempts cascade", 16'(cpu_int), 16'd1);
    ack(v);
    chk("R3 vector line 1", 16'(v), 16'h21);
    rd(P_ISR, v); chk("R6 nested primary isr", 16'(v), 16'h26);
    rd(S_ISR, v); chk("R6 nested secondary isr", 16'(v), 16'h10);
    irq = 16'(1) << 9; step();
    chk("R5 line 9 blocked by cascade in service", 16'(cpu_int), 16'd0);
    wr(P_REQ, 8'h00);
    rd(P_ISR, v); chk("R7 clears line 1 only", 16'(v), 16'h24);
    chk("R7 still blocked after one eoi", 16'(cpu_int), 16'd0);
    wr(S_REQ, 8'h00);
    rd(S_ISR, v); chk("R7 secondary cleared", 16'(v), 16'h00);
    chk("R7 blocked until primary eoi", 16'(cpu_int), 16'd0);
    wr(P_REQ, 8'h00);
    chk("R7 released after both eois", 16'(cpu_int), 16'd1);
    ack(v);
    chk("R3 vector line 9", 16'(v), 16'h29);
    irq = '0;
    wr(S_REQ, 8'h00); wr(P_REQ, 8'h00); wr(P_REQ, 8'h00);
    rd(P_ISR, v); chk("R7 all primary cleared", 16'(v), 16'h00);

    // R8 withdrawn requests
    irq = 16'(1) << 4; step();
    chk("R9 int follows line", 16'(cpu_int), 16'd1);
    irq = '0; step();
    chk("R9 int follows drop", 16'(cpu_int), 16'd0);
    ack(v);
    chk("R8 withdrawn primary gives base+7", 16'(v), 16'h27);
    rd(P_ISR, v); chk("R8 isr untouched", 16'(v), 16'h00);
    irq = 16'(1) << 13; step();
    irq = '0; step();
    ack(v);
    chk("R8 withdrawn secondary gives primary base+7", 16'(v), 16'h27);
    rd(S_ISR, v); chk("R8 secondary isr untouched", 16'(v), 16'h00);
    step();
    chk("R9 vec_vld single cycle", 16'(vec_vld), 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 run did not complete actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule